// File: doc/BRIEF.md
# I2C Serial Byte-Memory Slave Engine

This block is the bus-facing half of a small serial byte memory. It watches SCL and SDA, which a system clock at least eight times the SCL rate oversamples. It finds START and STOP conditions and compares the 7-bit device address. It answers with an active-high enable that pulls SDA low. Write transfers load a word-address pointer and then fill a page buffer. Read transfers return bytes from a synchronous RAM that stands in for the non-volatile array.

A write ends with STOP. The STOP copies the buffered page into the RAM and starts a programming interval of fixed length. During that interval the engine stays off the bus and does not answer its own address. Reads may begin at a word address loaded by a dummy write followed by a repeated START. They may also begin wherever the pointer already stands. In both cases they continue through successive locations for as long as the master acknowledges.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is asserted, and after it is released, the SDA pull-down enable is low and the engine is idle.
- R2: After START, a byte whose upper seven bits equal DEV_ADDR (bit 0 is read when 1, write when 0) is acknowledged by holding SDA low through the ninth SCL high phase. Any other address gets no acknowledge. The engine then stays silent until the next START or STOP.
- R3: In a write, the word-address byte and every data byte are acknowledged. Data is received MSB first. Each byte goes to the pointer location. Only the low PAGE_W pointer bits then advance, so writing past the end of a page wraps to the page start and overwrites earlier bytes, with the last byte written taking effect.
- R4: A STOP that follows at least one data byte commits the page and starts a busy interval of PROG_CYCLES clocks. After the interval, the new bytes can be read. A STOP after only a word address moves the pointer and starts no busy interval.
- R5: During the busy interval, no address is acknowledged, and the SDA enable stays low.
- R6: Read data is sent MSB first. After each byte the whole pointer advances by one and wraps from the top address to 0. A master acknowledge brings the next location.
- R7: If the master does not acknowledge a read byte, SDA is released and further clocks are ignored until STOP or START.
- R8: A read with no word-address phase begins at the current pointer, which is the location after the last byte transferred.
- R9: A START in the middle of a transfer restarts address matching. A dummy write followed by a repeated START therefore reads from the new word address.
- R10: A STOP at any point, including mid-byte, returns the engine to idle with SDA released. A partial data byte is never stored.
- R11: The SDA enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Active-high SDA pull-down enable |

## Verification
The bench builds the engine with a 6-bit word address (64 bytes), 8-byte pages, device address 0x52 and a 400-clock programming interval. At that size every one of the 128 device addresses is swept. Every location is written page by page, and the whole array is read in one sequential pass that also crosses the pointer wrap back to 0. The short page makes the in-page write wrap reachable with ten bytes. The 400-clock busy interval is long enough that an address probe sent straight after STOP lands inside it.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
   typedef enum logic [2:0] {
      XS_IDLE,
      XS_DEV,
      XS_WADDR,
      XS_WDATA,
      XS_RDATA,
      XS_WAIT
   } xfer_state_e;

   localparam int BYTE_BITS = 8;
   localparam int DEV_BITS  = 7;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   // bus idles high, so the chain resets to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
   import i2c_mem_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter int         ADDR_W   = 8,
   parameter int         PAGE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              busy,
   input  logic [7:0]        rd_data,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_valid,
   output logic [7:0]        wr_data,
   output logic              commit,
   output logic              discard
);
   localparam int CNT_W = $clog2(BYTE_BITS + 1);

   xfer_state_e       st;
   logic [CNT_W-1:0]  bit_cnt;
   logic              in_ack;
   logic [7:0]        shreg;
   logic              rw;
   logic              mack;
   logic              wrote_any;
   logic              byte_done;
   logic              dev_hit;
   logic [PAGE_W-1:0] off_nx;

   assign byte_done = scl_fall & ~in_ack & (bit_cnt == CNT_W'(BYTE_BITS));
   assign dev_hit   = (shreg[7:1] == DEV_ADDR) & ~busy;
   assign off_nx    = ptr[PAGE_W-1:0] + 1'b1;
   assign wr_valid  = (st == XS_WDATA) & byte_done;
   assign wr_data   = shreg;
   assign commit    = stop_det & wrote_any;
   assign discard   = start_det & wrote_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= XS_IDLE;
         bit_cnt   <= '0;
         in_ack    <= 1'b0;
         shreg     <= '0;
         rw        <= 1'b0;
         mack      <= 1'b0;
         wrote_any <= 1'b0;
         sda_oe    <= 1'b0;
         ptr       <= '0;
      end else if (stop_det) begin
         st        <= XS_IDLE;
         bit_cnt   <= '0;
         in_ack    <= 1'b0;
         wrote_any <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (start_det) begin
         st        <= busy ? XS_IDLE : XS_DEV;
         bit_cnt   <= '0;
         in_ack    <= 1'b0;
         wrote_any <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         unique case (st)
            XS_DEV, XS_WADDR, XS_WDATA: begin
               if (scl_rise && !in_ack && bit_cnt < CNT_W'(BYTE_BITS)) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_done) begin
                  if (st == XS_DEV) begin
                     if (dev_hit) begin
                        rw     <= shreg[0];
                        sda_oe <= 1'b1;
                        in_ack <= 1'b1;
                     end else begin
                        st <= XS_WAIT;
                     end
                  end else if (st == XS_WADDR) begin
                     ptr    <= shreg[ADDR_W-1:0];
                     sda_oe <= 1'b1;
                     in_ack <= 1'b1;
                  end else begin
                     ptr       <= {ptr[ADDR_W-1:PAGE_W], off_nx};
                     wrote_any <= 1'b1;
                     sda_oe    <= 1'b1;
                     in_ack    <= 1'b1;
                  end
               end else if (scl_fall && in_ack) begin
                  in_ack  <= 1'b0;
                  bit_cnt <= '0;
                  if (st == XS_DEV && rw) begin
                     st     <= XS_RDATA;
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= (st == XS_DEV) ? XS_WADDR : XS_WDATA;
                  end
               end
            end
            XS_RDATA: begin
               if (in_ack) begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     in_ack  <= 1'b0;
                     bit_cnt <= '0;
                     if (mack) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                     end else begin
                        st     <= XS_WAIT;
                        sda_oe <= 1'b0;
                     end
                  end
               end else begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt == CNT_W'(BYTE_BITS)) begin
                        sda_oe <= 1'b0;
                        in_ack <= 1'b1;
                        ptr    <= ptr + 1'b1;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
            end
            default: begin
               sda_oe <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/mem_page_store.sv
module mem_page_store #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 4,
   parameter int PROG_CYCLES = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              commit,
   input  logic              discard,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int BASE_W     = ADDR_W - PAGE_W;

   logic [7:0]            mem  [DEPTH];
   logic [7:0]            pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] pmask;
   logic [BASE_W-1:0]     pbase;
   logic [PAGE_W-1:0]     woff;

   assign woff = wr_addr[PAGE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pmask <= '0;
         pbase <= '0;
      end else if (commit || discard) begin
         pmask <= '0;
      end else if (wr_valid) begin
         pmask[woff] <= 1'b1;
         pbase       <= wr_addr[ADDR_W-1:PAGE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_valid) pbuf[woff] <= wr_data;
   end

   // whole page lands in one cycle; only lanes that were written move
   always_ff @(posedge clk) begin
      if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pmask[i]) mem[{pbase, PAGE_W'(i)}] <= pbuf[i];
         end
      end
      rd_data <= mem[rd_addr];
   end

   generate
      if (PROG_CYCLES > 0) begin : g_timed
         localparam int TW = $clog2(PROG_CYCLES + 1);
         logic [TW-1:0] tmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          tmr <= '0;
            else if (commit)     tmr <= TW'(PROG_CYCLES);
            else if (tmr != '0)  tmr <= tmr - 1'b1;
         end
         assign busy = (tmr != '0);
      end else begin : g_instant
         assign busy = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_W      = 4,
   parameter int         PROG_CYCLES = 5000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);
   generate
      if (ADDR_W > 8 || ADDR_W <= PAGE_W) begin : g_bad_addr
         $error("ADDR_W must exceed PAGE_W and fit one address byte");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("PAGE_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PROG_CYCLES < 0) begin : g_bad_prog
         $error("PROG_CYCLES must not be negative");
      end
   endgenerate

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              prog_busy;
   logic              commit;
   logic              discard;
   logic              wr_valid;
   logic [7:0]        wr_data;
   logic [7:0]        rd_data;
   logic [ADDR_W-1:0] ptr;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_xfer_fsm #(
      .DEV_ADDR (DEV_ADDR),
      .ADDR_W   (ADDR_W),
      .PAGE_W   (PAGE_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .busy      (prog_busy),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe_o),
      .ptr       (ptr),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .commit    (commit),
      .discard   (discard)
   );

   mem_page_store #(
      .ADDR_W      (ADDR_W),
      .PAGE_W      (PAGE_W),
      .PROG_CYCLES (PROG_CYCLES)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_addr  (ptr),
      .wr_data  (wr_data),
      .commit   (commit),
      .discard  (discard),
      .rd_addr  (ptr),
      .rd_data  (rd_data),
      .busy     (prog_busy)
   );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 4,
   parameter int PROG_CYCLES = 5000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_oe,
   input logic              scl_s,
   input logic              stop_det,
   input logic              busy,
   input logic              commit,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] ptr
);
   logic [31:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_oe); // R5
   AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) commit |-> !busy); // R5
   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_run <= 32'(PROG_CYCLES)); // R4
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_oe); // R10
   AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !$past(scl_s)); // R11
   AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R3
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(
   .ADDR_W      (ADDR_W),
   .PAGE_W      (PAGE_W),
   .PROG_CYCLES (PROG_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_oe   (sda_oe_o),
   .scl_s    (scl_s),
   .stop_det (stop_det),
   .busy     (prog_busy),
   .commit   (commit),
   .wr_valid (wr_valid),
   .ptr      (ptr)
);

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
   localparam logic [6:0] DEV   = 7'h52;
   localparam int         AW    = 6;
   localparam int         PW    = 3;
   localparam int         PROG  = 400;
   localparam int         DEPTH = 1 << AW;
   localparam int         PB    = 1 << PW;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe;
   logic sda_bus;

   assign sda_bus = ~(m_low | sda_oe);

   always #4 clk = ~clk;

   int         errs   = 0;
   int         checks = 0;
   int         viol   = 0;
   int         hi_cnt = 0;
   logic       prev_oe = 1'b0;
   logic [7:0] exp_mem [DEPTH];

   i2c_mem_slave #(
      .DEV_ADDR    (DEV),
      .ADDR_W      (AW),
      .PAGE_W      (PW),
      .PROG_CYCLES (PROG),
      .SYNC_STAGES (2)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_bus),
      .sda_oe_o (sda_oe)
   );

   // R11 monitor: enable must not move once SCL has been high a while
   always @(negedge clk) begin
      if (m_scl) hi_cnt = hi_cnt + 1;
      else       hi_cnt = 0;
      if (rst_n && hi_cnt >= 2 && sda_oe != prev_oe) viol = viol + 1;
      prev_oe = sda_oe;
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) ^ 'h5A);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic q();
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; q();
      m_scl = 1'b1; q();
      m_low = 1'b1; q();
      m_scl = 1'b0; q();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; q();
      m_scl = 1'b1; q();
      m_low = 1'b0; q();
      q();
   endtask

   task automatic put_bit(input bit b);
      m_low = ~b; q();
      m_scl = 1'b1; q(); q();
      m_scl = 1'b0; q();
   endtask

   task automatic put_byte(input logic [7:0] v, output bit ack);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      m_low = 1'b0; q();
      m_scl = 1'b1; q();
      ack = ~sda_bus; q();
      m_scl = 1'b0; q();
   endtask

   task automatic get_byte(input bit give_ack, output logic [7:0] v);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         q();
         m_scl = 1'b1; q();
         v[i] = sda_bus; q();
         m_scl = 1'b0;
      end
      q();
      m_low = give_ack; q();
      m_scl = 1'b1; q(); q();
      m_scl = 1'b0; q();
      m_low = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      summary();
      $finish;
   end

   initial begin
      bit         ack;
      logic [7:0] v;

      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 enable in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 enable after reset", sda_oe, 0);

      // R2 sweep of every device address
      for (int a = 0; a < 128; a++) begin
         bus_start();
         put_byte({7'(a), 1'b0}, ack);
         chk(ack == (a == int'(DEV)), "R2 address sweep", ack, (a == int'(DEV)));
         bus_stop();
      end

      // R2 silent after mismatch
      bus_start();
      put_byte({DEV ^ 7'h01, 1'b1}, ack);
      chk(!ack, "R2 foreign address", ack, 0);
      put_byte(8'h00, ack);
      chk(!ack, "R2 silent after mismatch", ack, 0);
      bus_stop();

      // R3 R4 R5 fill every page
      for (int p = 0; p < DEPTH / PB; p++) begin
         bus_start();
         put_byte({DEV, 1'b0}, ack);
         chk(ack, "R4 address acked once idle", ack, 1);
         put_byte(8'(p * PB), ack);
         chk(ack, "R3 word address ack", ack, 1);
         for (int k = 0; k < PB; k++) begin
            put_byte(pat(p * PB + k), ack);
            chk(ack, "R3 data ack", ack, 1);
            exp_mem[p * PB + k] = pat(p * PB + k);
         end
         bus_stop();
         bus_start();
         put_byte({DEV, 1'b0}, ack);
         chk(!ack, "R5 no ack while programming", ack, 0);
         bus_stop();
         repeat (PROG) @(negedge clk);
      end

      // R9 R6 sequential read over the whole array plus wrap
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      put_byte(8'h00, ack);
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      chk(ack, "R9 read address after repeated start", ack, 1);
      for (int i = 0; i <= DEPTH; i++) begin
         get_byte(i < DEPTH, v);
         chk(v == exp_mem[i % DEPTH], "R6 sequential read", v, exp_mem[i % DEPTH]);
      end
      bus_stop();

      // R8 current address read continues after the wrap
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      get_byte(1'b0, v);
      chk(v == exp_mem[1], "R8 current address read", v, exp_mem[1]);
      bus_stop();

      // R3 page wrap: ten bytes from offset 6 of page 2
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      put_byte(8'(2 * PB + 6), ack);
      for (int k = 0; k < 10; k++) begin
         put_byte(8'(8'hA0 + k), ack);
         chk(ack, "R3 wrap data ack", ack, 1);
         exp_mem[2 * PB + ((6 + k) % PB)] = 8'(8'hA0 + k);
      end
      bus_stop();
      repeat (PROG + 20) @(negedge clk);
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      get_byte(1'b0, v);
      chk(v == exp_mem[2 * PB], "R8 pointer after page wrap", v, exp_mem[2 * PB]);
      bus_stop();
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      put_byte(8'(2 * PB), ack);
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      for (int k = 0; k < PB; k++) begin
         get_byte(k < PB - 1, v);
         chk(v == exp_mem[2 * PB + k], "R3 page contents after wrap", v, exp_mem[2 * PB + k]);
      end
      bus_stop();

      // R7 master NACK ends the read
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      put_byte(8'd5, ack);
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      get_byte(1'b0, v);
      chk(v == exp_mem[5], "R7 byte before nack", v, exp_mem[5]);
      get_byte(1'b0, v);
      chk(v == 8'hFF, "R7 released after nack", v, 8'hFF);
      bus_stop();
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      get_byte(1'b0, v);
      chk(v == exp_mem[6], "R7 pointer advanced once", v, exp_mem[6]);
      bus_stop();

      // R4 address-only write starts no programming
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      put_byte(8'd40, ack);
      bus_stop();
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      chk(ack, "R4 no busy after address-only write", ack, 1);
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      get_byte(1'b0, v);
      chk(v == exp_mem[40], "R4 pointer set by address-only write", v, exp_mem[40]);
      bus_stop();

      // R10 STOP in the middle of a data byte
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      put_byte(8'd3, ack);
      put_bit(1'b1);
      put_bit(1'b0);
      put_bit(1'b1);
      put_bit(1'b0);
      bus_stop();
      chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      chk(ack, "R10 idle and responsive", ack, 1);
      put_byte(8'd3, ack);
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      get_byte(1'b0, v);
      chk(v == exp_mem[3], "R10 partial byte not stored", v, exp_mem[3]);
      bus_stop();

      repeat (10) @(negedge clk);
      chk(viol == 0, "R11 enable moved while SCL high", viol, 0);

      summary();
      $finish;
   end
endmodule